// File: doc/BRIEF.md
# Signed Integer Encoding Converter

This block translates an n-bit signed code from one of four encodings into another. The four encodings are sign-and-magnitude, ones' complement, two's complement and biased (excess-K). The block is purely combinational. A decoder turns the incoming code into a common signed value that is two bits wider than the code. An encoder then produces the destination code from that value and checks whether the value fits the destination range.

The block raises two flags. One marks a value that cannot be expressed in the destination encoding; in that case the output code is forced to all zeros. The other marks an input that is a negative zero. When the source and destination encodings are the same, the input code passes through untouched.

A binary-point parameter supports fixed-point codes. Every encoding except the biased one is insensitive to the binary-point position. The bias is given in whole units and is shifted left by the number of fraction bits to form the bias in code units.

Top module: `enc_convert`

## Requirements
- R1: A non-negative value produces the same code in sign-and-magnitude, ones' complement and two's complement, and the MSB of that code is 0. The format select encodings are: 0 = sign-and-magnitude, 1 = ones' complement, 2 = two's complement, 3 = biased.
- R2: In sign-and-magnitude, the MSB is the sign bit (1 = negative) and the lower WIDTH-1 bits are the absolute value in plain binary.
- R3: A negative ones'-complement code is the sign-and-magnitude code with all lower WIDTH-1 bits inverted.
- R4: A negative two's-complement code is the ones'-complement code plus one, so the MSB weighs -2^(WIDTH-1). The code with only the MSB set has no sign-and-magnitude or ones'-complement form.
- R5: A biased code decodes to its unsigned value minus the bias. With WIDTH=4 and bias 3, code 0000 means -3 and code 0001 means -2.
- R6: Sign-and-magnitude code 10..0 and ones'-complement code 11..1 set the negative-zero flag. Both convert to the code for zero in the other encodings.
- R7: When the value lies outside the destination range, the unrepresentable flag is 1 and the output code is all zeros. Otherwise the flag is 0.
- R8: When the source and destination selects are equal, the output equals the input and the unrepresentable flag is 0. The negative-zero flag still follows R6.
- R9: With FRAC_BITS fraction bits, the bias in code units is BIAS shifted left by FRAC_BITS. Negation of a fixed-point code follows the same rule as for integers: with WIDTH=6 and FRAC_BITS=2, sign-and-magnitude 1101.01 becomes two's complement 1010.11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code_i | input | WIDTH | Incoming code |
| src_fmt_i | input | 2 | Encoding of code_i |
| dst_fmt_i | input | 2 | Encoding wanted on code_o |
| code_o | output | WIDTH | Converted code |
| unrep_o | output | 1 | Value has no form in the destination encoding |
| negzero_o | output | 1 | code_i is a negative zero in its encoding |

## Verification
The bench sweeps every 4-bit code through all sixteen pairs of source and destination encodings, with a bias of 3. Each expected result is computed from integer arithmetic in the bench. This sweep exposes a most-negative two's-complement code that wraps to a bogus sign-and-magnitude pattern instead of being flagged. It also catches a biased value above the symmetric range that leaks through, and a negative zero that comes out as 1000 in two's complement. A missing ones'-complement end correction would show as every negative result being off by one. A pass-through path that rewrites negative zero would be caught as well. A second instance with two fraction bits checks that the bias is scaled by the binary point and that fractional negation lands on the expected bit pattern.

// File: rtl/enc_pkg.sv
package enc_pkg;

  typedef enum logic [1:0] {
    FMT_SIGNMAG = 2'd0,
    FMT_ONESC   = 2'd1,
    FMT_TWOSC   = 2'd2,
    FMT_BIASED  = 2'd3
  } fmt_e;

endpackage

// File: rtl/enc_decode.sv
module enc_decode #(
  parameter int WIDTH     = 8,
  parameter int IW        = WIDTH + 2,
  parameter int BIAS_CODE = 127
) (
  input  logic [WIDTH-1:0]     code_i,
  input  enc_pkg::fmt_e        fmt_i,
  output logic signed [IW-1:0] value_o,
  output logic                 negzero_o
);
  localparam int MAGW = WIDTH - 1;
  localparam logic [IW-1:0] BIAS_V = IW'(BIAS_CODE);

  // two's-complement negation: keep bits up to the lowest 1, invert above
  function automatic logic [IW-1:0] negate(input logic [IW-1:0] x);
    logic [IW-1:0] r;
    logic          seen;
    seen = 1'b0;
    for (int i = 0; i < IW; i++) begin
      r[i] = seen ? ~x[i] : x[i];
      if (x[i]) seen = 1'b1;
    end
    return r;
  endfunction

  logic                 sign_bit;
  logic [IW-1:0]        mag_ext;
  logic [IW-1:0]        sext;
  logic signed [IW-1:0] value_d;
  logic                 nz_d;

  always_comb begin
    sign_bit = code_i[WIDTH-1];
    mag_ext  = IW'(code_i[MAGW-1:0]);
    sext     = {{(IW-WIDTH){sign_bit}}, code_i};
    value_d  = '0;
    nz_d     = 1'b0;
    case (fmt_i)
      enc_pkg::FMT_SIGNMAG: begin
        value_d = sign_bit ? negate(mag_ext) : mag_ext;
        nz_d    = sign_bit && (code_i[MAGW-1:0] == '0);
      end
      enc_pkg::FMT_ONESC: begin
        value_d = sign_bit ? sext + IW'(1) : sext;
        nz_d    = &code_i;
      end
      enc_pkg::FMT_TWOSC: begin
        value_d = sext;
      end
      default: begin
        value_d = IW'(code_i) - BIAS_V;
      end
    endcase

    if (nz_d) begin
      assert_negzero_is_zero_R6: assert (value_d == '0)
        else $error("negative zero decoded to nonzero value");
    end
    if ((fmt_i != enc_pkg::FMT_BIASED) && sign_bit && !nz_d) begin
      assert_sign_bit_negative_R2: assert (value_d[IW-1])
        else $error("sign bit set but value not negative");
    end
  end

  assign value_o   = value_d;
  assign negzero_o = nz_d;

endmodule

// File: rtl/enc_encode.sv
module enc_encode #(
  parameter int WIDTH     = 8,
  parameter int IW        = WIDTH + 2,
  parameter int BIAS_CODE = 127
) (
  input  logic signed [IW-1:0] value_i,
  input  enc_pkg::fmt_e        fmt_i,
  output logic [WIDTH-1:0]     code_o,
  output logic                 unrep_o
);
  localparam logic signed [IW-1:0] SYM_MAX = IW'((1 << (WIDTH - 1)) - 1);
  localparam logic signed [IW-1:0] SYM_MIN = -SYM_MAX;
  localparam logic signed [IW-1:0] TC_MIN  = IW'(-(1 << (WIDTH - 1)));
  localparam logic signed [IW-1:0] XS_MIN  = IW'(-BIAS_CODE);
  localparam logic signed [IW-1:0] XS_MAX  = IW'((1 << WIDTH) - 1 - BIAS_CODE);
  localparam logic signed [IW-1:0] BIAS_V  = IW'(BIAS_CODE);

  logic                 neg;
  logic [WIDTH-2:0]     mag;
  logic [WIDTH-1:0]     code_d;
  logic                 fits;
  logic signed [IW-1:0] minus_one;
  logic signed [IW-1:0] shifted;

  always_comb begin
    neg       = value_i[IW-1];
    mag       = neg ? (WIDTH-1)'(-value_i) : (WIDTH-1)'(value_i);
    minus_one = value_i - IW'(1);
    shifted   = value_i + BIAS_V;
    code_d    = '0;
    fits      = 1'b0;
    case (fmt_i)
      enc_pkg::FMT_SIGNMAG: begin
        fits   = (value_i >= SYM_MIN) && (value_i <= SYM_MAX);
        code_d = {neg, mag};
      end
      enc_pkg::FMT_ONESC: begin
        fits   = (value_i >= SYM_MIN) && (value_i <= SYM_MAX);
        code_d = neg ? WIDTH'(minus_one) : WIDTH'(value_i);
      end
      enc_pkg::FMT_TWOSC: begin
        fits   = (value_i >= TC_MIN) && (value_i <= SYM_MAX);
        code_d = WIDTH'(value_i);
      end
      default: begin
        fits   = (value_i >= XS_MIN) && (value_i <= XS_MAX);
        code_d = WIDTH'(shifted);
      end
    endcase

    if (fits && !neg && (fmt_i != enc_pkg::FMT_BIASED)) begin
      assert_nonneg_msb_clear_R1: assert (code_d[WIDTH-1] == 1'b0)
        else $error("non-negative value encoded with MSB set");
    end
  end

  assign code_o  = fits ? code_d : '0;
  assign unrep_o = !fits;

endmodule

// File: rtl/enc_convert.sv
module enc_convert #(
  parameter int WIDTH     = 8,
  parameter int FRAC_BITS = 0,
  parameter int BIAS      = 127
) (
  input  logic [WIDTH-1:0] code_i,
  input  logic [1:0]       src_fmt_i,
  input  logic [1:0]       dst_fmt_i,
  output logic [WIDTH-1:0] code_o,
  output logic             unrep_o,
  output logic             negzero_o
);
  localparam int IW        = WIDTH + 2;
  localparam int BIAS_CODE = BIAS << FRAC_BITS;

  enc_pkg::fmt_e        src_fmt;
  enc_pkg::fmt_e        dst_fmt;
  logic signed [IW-1:0] mid_value;
  logic [WIDTH-1:0]     enc_code;
  logic                 enc_unrep;
  logic                 same_fmt;

  assign src_fmt  = enc_pkg::fmt_e'(src_fmt_i);
  assign dst_fmt  = enc_pkg::fmt_e'(dst_fmt_i);
  assign same_fmt = (src_fmt_i == dst_fmt_i);

  enc_decode #(.WIDTH(WIDTH), .IW(IW), .BIAS_CODE(BIAS_CODE)) u_dec (
    .code_i   (code_i),
    .fmt_i    (src_fmt),
    .value_o  (mid_value),
    .negzero_o(negzero_o)
  );

  enc_encode #(.WIDTH(WIDTH), .IW(IW), .BIAS_CODE(BIAS_CODE)) u_enc (
    .value_i(mid_value),
    .fmt_i  (dst_fmt),
    .code_o (enc_code),
    .unrep_o(enc_unrep)
  );

  assign code_o  = same_fmt ? code_i : enc_code;
  assign unrep_o = same_fmt ? 1'b0 : enc_unrep;

  always_comb begin
    if (unrep_o) begin
      assert_unrep_zero_out_R7: assert (code_o == '0)
        else $error("unrepresentable value left a nonzero code");
    end
    if (src_fmt_i == dst_fmt_i) begin
      assert_same_fmt_pass_R8: assert ((code_o == code_i) && !unrep_o)
        else $error("same-format conversion altered the code");
    end
  end

endmodule

// File: tb/enc_convert_test.sv
module enc_convert_test;
  localparam int W  = 4;
  localparam int B  = 3;
  localparam int FW = 6;

  logic clk;
  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [W-1:0]  code_i;
  logic [1:0]    sfmt, dfmt;
  logic [W-1:0]  code_o;
  logic          unrep_o, negzero_o;

  logic [FW-1:0] fcode_i, fcode_o;
  logic [1:0]    fsfmt, fdfmt;
  logic          funrep, fnz;

  enc_convert #(.WIDTH(W), .FRAC_BITS(0), .BIAS(B)) uut (
    .code_i(code_i), .src_fmt_i(sfmt), .dst_fmt_i(dfmt),
    .code_o(code_o), .unrep_o(unrep_o), .negzero_o(negzero_o)
  );

  enc_convert #(.WIDTH(FW), .FRAC_BITS(2), .BIAS(1)) uut_fix (
    .code_i(fcode_i), .src_fmt_i(fsfmt), .dst_fmt_i(fdfmt),
    .code_o(fcode_o), .unrep_o(funrep), .negzero_o(fnz)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int decode(int c, int f);
    int s;
    s = (c >> (W - 1)) & 1;
    case (f)
      0: return s ? -(c - (1 << (W - 1))) : c;
      1: return s ? c - ((1 << W) - 1) : c;
      2: return s ? c - (1 << W) : c;
      default: return c - B;
    endcase
  endfunction

  function automatic bit fits(int v, int f);
    int hi;
    hi = (1 << (W - 1)) - 1;
    case (f)
      0, 1: return (v >= -hi) && (v <= hi);
      2: return (v >= -hi - 1) && (v <= hi);
      default: return (v >= -B) && (v <= (1 << W) - 1 - B);
    endcase
  endfunction

  function automatic int encode(int v, int f);
    case (f)
      0: return (v < 0) ? (1 << (W - 1)) - v : v;
      1: return (v < 0) ? v + (1 << W) - 1 : v;
      2: return (v < 0) ? v + (1 << W) : v;
      default: return v + B;
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  initial begin
    code_i = '0; sfmt = '0; dfmt = '0;
    fcode_i = '0; fsfmt = '0; fdfmt = '0;
    repeat (2) @(posedge clk);

    // exhaustive sweep, 4-bit codes, bias 3
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int c = 0; c < 16; c++) begin
          int  v, eo;
          bit  enz, eun;
          string tag;
          @(negedge clk);
          code_i = W'(c); sfmt = 2'(s); dfmt = 2'(d);
          @(posedge clk); #2;
          v   = decode(c, s);
          enz = (s == 0 && c == 8) || (s == 1 && c == 15);
          if (s == d) begin
            eun = 1'b0; eo = c; tag = "R8";
          end else begin
            eun = !fits(v, d);
            eo  = eun ? 0 : encode(v, d);
            if (enz) tag = "R6";
            else if (eun) tag = "R7";
            else if (s == 3 || d == 3) tag = "R5";
            else if (v < 0 && (s == 2 || d == 2)) tag = "R4";
            else if (v < 0 && (s == 1 || d == 1)) tag = "R3";
            else if (v < 0) tag = "R2";
            else tag = "R1";
          end
          check(tag, {code_o, unrep_o, negzero_o}, {eo[W-1:0], eun, enz});
        end
      end
    end

    // R4: most negative two's complement into sign-magnitude
    @(negedge clk); code_i = 4'b1000; sfmt = 2'd2; dfmt = 2'd0;
    @(posedge clk); #2; check("R4", {code_o, unrep_o}, {4'b0000, 1'b1});
    // R5: biased 0000 is -3 -> two's complement 1101
    @(negedge clk); code_i = 4'b0000; sfmt = 2'd3; dfmt = 2'd2;
    @(posedge clk); #2; check("R5", code_o, 4'b1101);
    // R5: biased 0001 is -2 -> sign-magnitude 1010
    @(negedge clk); code_i = 4'b0001; sfmt = 2'd3; dfmt = 2'd0;
    @(posedge clk); #2; check("R5", code_o, 4'b1010);
    // R6: ones' complement negative zero -> biased zero (code 3)
    @(negedge clk); code_i = 4'b1111; sfmt = 2'd1; dfmt = 2'd3;
    @(posedge clk); #2; check("R6", {code_o, negzero_o}, {4'b0011, 1'b1});

    // R9: fixed point, 6 bits with 2 fraction bits, bias 1.0 = code 000100
    @(negedge clk); fcode_i = 6'b110101; fsfmt = 2'd0; fdfmt = 2'd2;
    @(posedge clk); #2; check("R9", {fcode_o, funrep}, {6'b101011, 1'b0});
    @(negedge clk); fcode_i = 6'b000100; fsfmt = 2'd3; fdfmt = 2'd2;
    @(posedge clk); #2; check("R9", {fcode_o, funrep}, {6'b000000, 1'b0});
    @(negedge clk); fcode_i = 6'b000101; fsfmt = 2'd2; fdfmt = 2'd3;
    @(posedge clk); #2; check("R9", {fcode_o, funrep}, {6'b001001, 1'b0});
    @(negedge clk); fcode_i = 6'b101011; fsfmt = 2'd2; fdfmt = 2'd3;
    @(posedge clk); #2; check("R9", {fcode_o, funrep}, {6'b000000, 1'b1});
    @(negedge clk); fcode_i = 6'b101011; fsfmt = 2'd2; fdfmt = 2'd1;
    @(posedge clk); #2; check("R9", {fcode_o, funrep}, {6'b101010, 1'b0});

    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule